// File: doc/BRIEF.md
# SMBus Indexed Block-Access Register Slave

This block is a serial-bus target that owns a small bank of byte-wide configuration registers. A host reaches the bank with indexed block transfers. A write names a starting index and a byte count, and then supplies the data bytes. A read first sets the index with a short write preamble. After a repeated start the host addresses the block for reading. The block answers with the current value of its byte-count register and then streams register contents from the index onward.

SCL and SDA arrive as raw levels and are sampled by the block clock through a synchronizer. The block pulls SDA low through a single open-drain enable output. Six control bytes leave the block on a parallel output bus. A 4-bit revision code enters on a parallel input and is read back as part of an identification byte. The bus pins are not a data stream with flow control, so there is no valid/ready handshake. All pins are plain levels, and pacing comes from the host's SCL alone.

Top module: `smb_blk_slave`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address byte the block leaves SDA released, for that ACK slot and for every later byte, until the next start or stop.
- R2: A write transfer carries 0xD2, a start index N, a count X and data bytes. Every one of these bytes is acknowledged. The data bytes are stored at N, N+1 and so on.
- R3: Data bytes beyond the count X in a write are acknowledged but not stored.
- R4: After a repeated start and 0xD3, the block sends first the byte-count register and then registers from the current index, MSB first.
- R5: Register 8 is the byte count. It resets to 0x09, it can be written, and its value is the first byte of every read.
- R6: Register 6 reads 0x12. Register 7 reads {rev_id_i[3:0], 4'b0001}. Writes to either are acknowledged and have no effect.
- R7: Registers 9 to 21 are reserved. Writes to them are acknowledged and ignored, and reads of them return 0x00. Indices above 21 also read 0x00.
- R8: The index advances by one after every data byte, written or read.
- R9: Control registers 0 to 5 reset to 0x00, 0xFF, 0x00, 0xFC, 0x0C and 0x00. Register i appears on ctrl_o[8i+7:8i].
- R10: A start or stop in the middle of a byte aborts the transfer, and no register is written. A start re-arms address reception.
- R11: When the host answers a read byte with a not-acknowledge, the block releases SDA and drives nothing more until a stop or start.
- R12: sda_oe_o changes only while the synchronized SCL is low. It is released after a stop and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus (wired-AND value) |
| rev_id_i | input | 4 | Revision code returned in register 7 bits 7:4 |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| ctrl_o | output | 48 | Control registers 0 to 5, register i in bits 8i+7:8i |

## Verification
Two functions can coincide: the completion of a data byte, which commits a register write, and a start or stop that cuts a byte short. The bench provokes this by sending four bits of a data byte and then issuing a stop, and in a second case a repeated start. The abort is judged correct when the target register still holds its old value, both in the every-clock comparison of ctrl_o and in a later read, and when the transfer that follows the repeated start is acknowledged and stored. A second overlap is the SCL fall on which the block releases SDA while the host takes over SDA for its own acknowledge. The bench models the wired-AND bus and checks the acknowledge level the host samples on each byte.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned N_CTRL     = 6;
  localparam int unsigned IDX_DEVID  = 6;
  localparam int unsigned IDX_VENDOR = 7;
  localparam int unsigned IDX_BCNT   = 8;
  localparam int unsigned IDX_LAST   = 21;
  localparam logic [7:0]  ADDR_WR    = 8'hD2;
  localparam logic [7:0]  ADDR_RD    = 8'hD3;
  localparam logic [7:0]  DEVID_VAL  = 8'h12;
  localparam logic [3:0]  VENDOR_VAL = 4'h1;
  localparam logic [7:0]  BCNT_RST   = 8'h09;

  function automatic logic [7:0] ctrl_rst(input int unsigned i);
    case (i)
      1:       return 8'hFF;
      3:       return 8'hFC;
      4:       return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_SETUP, ST_ACK_HOLD, ST_TX, ST_TX_ACK, ST_WAIT
  } link_st_e;

  typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_CNT, PH_DATA} rx_ph_e;
endpackage

// File: rtl/smb_sync_edge.sv
module smb_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               wr_idx,
  input  logic [7:0]               wr_data,
  input  logic [7:0]               rd_idx,
  input  logic [3:0]               rev_id_i,
  output logic [7:0]               rd_data,
  output logic [7:0]               bcnt_o,
  output logic [N_CTRL*BYTE_W-1:0] ctrl_o
);
  logic [7:0] ctrl_q [N_CTRL];
  logic [7:0] bcnt_q;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q[g] <= ctrl_rst(g);
      else if (wr_en && wr_idx == 8'(g))      ctrl_q[g] <= wr_data;
    end
    assign ctrl_o[g*BYTE_W +: BYTE_W] = ctrl_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               bcnt_q <= BCNT_RST;
    else if (wr_en && wr_idx == 8'(IDX_BCNT)) bcnt_q <= wr_data;
  end
  assign bcnt_o = bcnt_q;

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < N_CTRL; i++)
      if (rd_idx == 8'(i)) rd_data = ctrl_q[i];
    if (rd_idx == 8'(IDX_DEVID))  rd_data = DEVID_VAL;
    if (rd_idx == 8'(IDX_VENDOR)) rd_data = {rev_id_i, VENDOR_VAL};
    if (rd_idx == 8'(IDX_BCNT))   rd_data = bcnt_q;
  end

  // R6, R7: writes to identification, reserved or out-of-range indices change nothing
  assert_ro_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 8'(IDX_DEVID) || wr_idx == 8'(IDX_VENDOR) || wr_idx > 8'(IDX_BCNT)))
    |=> ($stable(ctrl_o) && $stable(bcnt_o)));
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  input  logic [7:0] bcnt,
  output logic       sda_oe_o,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] idx_o
);
  link_st_e   st;
  rx_ph_e     ph;
  logic [2:0] bitcnt;
  logic [7:0] rxsh, txsh, idx, wr_left;
  logic       is_read, do_ack, mack;
  logic [7:0] rx_byte;

  assign rx_byte = {rxsh[6:0], sda_s};
  assign idx_o   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  ph <= PH_ADDR;  bitcnt <= '0;
      rxsh <= '0;  txsh <= '0;  idx <= '0;  wr_left <= '0;
      is_read <= 1'b0;  do_ack <= 1'b0;  mack <= 1'b0;
      sda_oe_o <= 1'b0;  wr_en <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= ST_RX;  ph <= PH_ADDR;  bitcnt <= '0;
        sda_oe_o <= 1'b0;  wr_left <= '0;
      end else if (stop_det) begin
        st <= ST_IDLE;  sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_rise) begin
            rxsh   <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              st     <= ST_ACK_SETUP;
              do_ack <= 1'b1;
              case (ph)
                PH_ADDR: begin
                  if (rx_byte == ADDR_WR)      is_read <= 1'b0;
                  else if (rx_byte == ADDR_RD) is_read <= 1'b1;
                  else                         do_ack  <= 1'b0;
                end
                PH_IDX:  idx     <= rx_byte;
                PH_CNT:  wr_left <= rx_byte;
                default: begin
                  wr_en   <= (wr_left != 8'd0);
                  wr_idx  <= idx;
                  wr_data <= rx_byte;
                  idx     <= idx + 8'd1;
                  if (wr_left != 8'd0) wr_left <= wr_left - 8'd1;
                end
              endcase
            end
          end
          ST_ACK_SETUP: if (scl_fall) begin
            if (do_ack) begin
              sda_oe_o <= 1'b1;
              st       <= ST_ACK_HOLD;
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_ACK_HOLD: if (scl_fall) begin
            bitcnt <= '0;
            if (ph == PH_ADDR && is_read) begin
              txsh     <= bcnt;
              sda_oe_o <= ~bcnt[7];
              st       <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              st       <= ST_RX;
              case (ph)
                PH_ADDR: ph <= PH_IDX;
                PH_IDX:  ph <= PH_CNT;
                default: ph <= PH_DATA;
              endcase
            end
          end
          ST_TX: if (scl_fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              st       <= ST_TX_ACK;
            end else begin
              sda_oe_o <= ~txsh[6];
              txsh     <= {txsh[6:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                txsh     <= rd_data;
                sda_oe_o <= ~rd_data[7];
                idx      <= idx + 8'd1;
                bitcnt   <= '0;
                st       <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: the drive enable moves only on a cycle that followed a low SCL sample
  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(!scl_s));
  // R12: a stop leaves SDA released
  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);
  // R11, R1: while parked after a host NACK or a foreign address, SDA is free
  assert_wait_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe_o);
  // R1: an unmatched address gets no acknowledge pulse
  assert_nack_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK_SETUP && !do_ack && !start_det) |=> !sda_oe_o);
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
  import smb_reg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [3:0]               rev_id_i,
  output logic                     sda_oe_o,
  output logic [N_CTRL*BYTE_W-1:0] ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [7:0] wr_idx, wr_data, idx, rd_data, bcnt;

  smb_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smb_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .bcnt(bcnt), .sda_oe_o(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .idx_o(idx));

  smb_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(idx), .rev_id_i(rev_id_i),
    .rd_data(rd_data), .bcnt_o(bcnt), .ctrl_o(ctrl_o));
endmodule

// File: tb/sim_smb_blk_slave.sv
`timescale 1ns/1ps
module sim_smb_blk_slave;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic [3:0] rev_id = 4'h3;
  logic sda_oe;
  logic [47:0] ctrl_o;
  wire  sda_bus = host_sda & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  bit model_live = 0;
  logic [7:0] m_ctrl [0:5];
  logic [7:0] m_bcnt;
  logic [7:0] rd_buf [0:15];
  logic [7:0] rd_cnt;
  logic       nack_oe;

  always #2.5 clk = ~clk;

  smb_blk_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .rev_id_i(rev_id), .sda_oe_o(sda_oe), .ctrl_o(ctrl_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    if (i < 6)  return m_ctrl[i];
    if (i == 6) return 8'h12;
    if (i == 7) return {rev_id, 4'h1};
    if (i == 8) return m_bcnt;
    return 8'h00;
  endfunction

  // reference comparison of the control bus on every clock while no write is in flight (R9, R2)
  always @(negedge clk) begin
    if (model_live && rst_n)
      for (int i = 0; i < 6; i++) begin
        checks++;
        if (ctrl_o[i*8 +: 8] !== m_ctrl[i]) begin
          errors++;
          $display("FAIL R9 ctrl byte %0d actual %0h expected %0h", i, ctrl_o[i*8 +: 8], m_ctrl[i]);
        end
      end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    host_sda = 1; wq(); host_scl = 1; wq(); host_sda = 0; wq(); host_scl = 0; wq();
  endtask

  task automatic bus_stop();
    host_sda = 0; wq(); host_scl = 1; wq(); host_sda = 1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; wq(); host_scl = 1; wq(); wq(); host_scl = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_sda = 1; wq(); host_scl = 1; wq(); ackd = ~sda_bus; wq(); host_scl = 0; wq();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    host_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); host_scl = 1; wq(); b[i] = sda_bus; wq(); host_scl = 0; wq();
    end
    send_bit(~ack);
    host_sda = 1;
  endtask

  task automatic smb_write(input int idx, input int cnt, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic a;
    logic [7:0] d [0:2];
    d[0] = d0; d[1] = d1; d[2] = d2;
    model_live = 0;
    bus_start();
    send_byte(8'hD2, a);       chk("R1 write address ack", a, 1);
    send_byte(8'(idx), a);     chk("R2 index ack", a, 1);
    send_byte(8'(cnt), a);     chk("R2 count ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a);      chk("R2 data ack", a, 1);
      if (k < cnt) begin
        if (idx + k < 6) m_ctrl[idx + k] = d[k];
        if (idx + k == 8) m_bcnt = d[k];
      end
    end
    bus_stop();
    chk("R12 released after stop", sda_oe, 0);
    wq();
    model_live = 1;
  endtask

  task automatic smb_read(input int idx, input int n);
    logic a;
    bus_start();
    send_byte(8'hD2, a);       chk("R1 write address ack", a, 1);
    send_byte(8'(idx), a);     chk("R2 index ack", a, 1);
    host_sda = 1; wq();
    bus_start();
    send_byte(8'hD3, a);       chk("R4 read address ack", a, 1);
    recv_byte(1'b1, rd_cnt);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rd_buf[k]);
    wq();
    nack_oe = sda_oe;
    bus_stop();
    wq();
  endtask

  initial begin
    logic a;
    logic [7:0] junk;
    for (int i = 0; i < 6; i++) m_ctrl[i] = 8'h00;
    m_ctrl[1] = 8'hFF; m_ctrl[3] = 8'hFC; m_ctrl[4] = 8'h0C;
    m_bcnt = 8'h09;
    repeat (10) @(negedge clk);
    chk("R12 oe during reset", sda_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) chk("R9 reset value", ctrl_o[i*8 +: 8], m_ctrl[i]);
    model_live = 1;

    // R2 R8: block write, then full read of the first nine registers
    smb_write(0, 3, 3, 8'hA5, 8'h3C, 8'h7E);
    smb_read(0, 9);
    chk("R5 count byte reset 09", rd_cnt, 8'h09);
    for (int k = 0; k < 9; k++) chk("R4 R8 read stream", rd_buf[k], exp_rd(k));
    chk("R11 released after host nack", nack_oe, 0);

    // R1: foreign address is not acknowledged, nor is any later byte
    bus_start();
    send_byte(8'hA0, a);  chk("R1 foreign address nack", a, 0);
    send_byte(8'h00, a);  chk("R1 silent after foreign address", a, 0);
    bus_stop();

    // R6: identification bytes are read-only
    smb_write(6, 2, 2, 8'hFF, 8'hFF, 8'h00);
    smb_read(6, 2);
    chk("R6 device id", rd_buf[0], 8'h12);
    chk("R6 vendor and revision", rd_buf[1], 8'h31);

    // R7: reserved writes ignored, reserved and out-of-range reads zero
    smb_write(9, 3, 3, 8'h11, 8'h22, 8'h33);
    smb_read(9, 3);
    for (int k = 0; k < 3; k++) chk("R7 reserved reads zero", rd_buf[k], 8'h00);
    smb_read(20, 3);
    for (int k = 0; k < 3; k++) chk("R7 beyond last index zero", rd_buf[k], 8'h00);

    // R3: bytes past the count are acked but dropped
    smb_write(3, 1, 3, 8'h55, 8'h66, 8'h77);
    smb_read(3, 3);
    chk("R3 counted byte stored", rd_buf[0], 8'h55);
    chk("R3 excess byte dropped", rd_buf[1], 8'h0C);
    chk("R3 excess byte dropped", rd_buf[2], 8'h00);

    // R5: byte-count register is writable and leads every read
    smb_write(8, 1, 1, 8'h04, 8'h00, 8'h00);
    smb_read(0, 4);
    chk("R5 count byte written", rd_cnt, 8'h04);
    for (int k = 0; k < 4; k++) chk("R4 stream after new count", rd_buf[k], exp_rd(k));
    smb_write(8, 1, 1, 8'h09, 8'h00, 8'h00);

    // R10: stop in the middle of a data byte
    model_live = 0;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h04, a); send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    model_live = 1;
    wq();
    smb_read(4, 1);
    chk("R10 stop abort no write", rd_buf[0], 8'h0C);

    // R10: repeated start in the middle of a data byte, then a full write
    model_live = 0;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h05, a); send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    host_sda = 1; wq();
    bus_start();
    send_byte(8'hD2, a);  chk("R10 address after abort ack", a, 1);
    send_byte(8'h05, a);  send_byte(8'h01, a);
    send_byte(8'h5A, a);  chk("R10 data after abort ack", a, 1);
    bus_stop();
    m_ctrl[5] = 8'h5A;
    wq();
    model_live = 1;
    smb_read(5, 1);
    chk("R10 write after restart stored", rd_buf[0], 8'h5A);

    // R6: revision input reflected in register 7
    rev_id = 4'hC;
    smb_read(7, 1);
    chk("R6 revision input", rd_buf[0], 8'hC1);
    junk = rd_cnt;
    chk("R5 count restored", junk, 8'h09);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule